// File: doc/BRIEF.md
# Masked Device Interrupt Router

This block takes 64 shared device interrupt lines and routes them to four processors. Each processor has its own 64-bit mask. A single global raw request register records which device lines are currently requesting. Devices raise and drop their requests through set and clear events that each name one line. Each processor's pending register always holds its mask ANDed with the raw request word. The block drives one level-sensitive interrupt output per processor, and that output is the registered OR of the processor's pending bits.

Software reaches the block over a small CSR bus with a one-cycle response. Registers are placed on 64-byte strides from a base address. Index 0 to 3 holds the masks of processors 0 to 3, and these are read/write. Index 4 to 7 holds the pending words of processors 0 to 3, and index 8 holds the raw request word; both of these are read-only. Only full 8-byte accesses are accepted. A narrow access, a write to a read-only register and any access outside the map are answered with an error flag and change nothing.

Top module: `imr_router`

## Requirements
- R1: A set event for line n (0..63) sets bit n of the raw request word, which reads back at register index 8.
- R2: After every mask write and every device event, pending of processor c (read at index 4+c) equals mask c AND the raw request word.
- R3: irq_out[c] is the OR of pending c. It changes one clock after the pending register, which is two rising edges after the event or write is presented.
- R4: A full write to index c (0..3) replaces mask c. Enabling a bit whose raw request is set asserts irq_out[c], and disabling the last such bit deasserts it.
- R5: A clear event for line n clears raw bit n. A clear of a line whose raw bit is already zero is spurious and changes no state.
- R6: When a set event and a clear event name the same line in the same cycle, the set wins and the raw bit ends up at 1.
- R7: The register index is (csr_addr - BASE) >> 6, and the low 6 address bits are ignored. An address below BASE or an index above 8 returns zero data with rsp_err=1 and changes no state.
- R8: csr_size counts bytes. Any value other than 8 gets rsp_err=1 with zero data and changes no state.
- R9: A write to a pending register (index 4..7) or to the raw register (index 8) gets rsp_err=1 and changes no state.
- R10: Reset clears every mask, pending and raw bit, drives irq_out to 0 and raises no response.
- R11: Each request gets exactly one response cycle: rsp_valid is high on the clock after csr_valid. Read data shows the registers as they stood before that edge, and writes return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_set_valid | input | 1 | Device set event strobe |
| dev_set_line | input | 6 | Line raised by the set event |
| dev_clr_valid | input | 1 | Device clear event strobe |
| dev_clr_line | input | 6 | Line dropped by the clear event |
| csr_valid | input | 1 | CSR request strobe |
| csr_write | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 16 | CSR byte address |
| csr_size | input | 4 | Access size in bytes |
| csr_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 64 | Read data, zero on error and on writes |
| irq_out | output | 4 | Level interrupt, one bit per processor |

## Verification
The routing function is exercised with lines at both ends of the word (5 and 63), with masks covering one bit, a 16-bit band or nothing, and with processors sharing a line or owning one alone. These cases show whether the AND works per processor and per bit position. Device events and mask writes are interleaved in both orders, so the bench can tell a mask enable that finds a request already waiting apart from a request that arrives under an existing mask. It also separates the case of a disable removing the last pending bit from a clear event doing the same. A spurious clear, a set and clear on the same line in one cycle, and a read issued in the same cycle as an event each check, in turn, the no-op rule, the ordering of set and clear, and the timing of read data.

// File: rtl/imr_pkg.sv
package imr_pkg;
  typedef enum logic [1:0] {
    KIND_MASK = 2'd0,
    KIND_PEND = 2'd1,
    KIND_RAW  = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/imr_csr_decode.sv
module imr_csr_decode
  import imr_pkg::*;
#(
  parameter int AW         = 16,
  parameter int SZW        = 4,
  parameter int NCPU       = 4,
  parameter int STRIDE_LG  = 6,
  parameter int FULL_BYTES = 8,
  parameter logic [AW-1:0] BASE = 16'h4000,
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic [AW-1:0]  addr,
  input  logic [SZW-1:0] size,
  output reg_kind_e      kind,
  output logic [CW-1:0]  cpu_sel,
  output logic           size_ok
);
  function automatic logic [AW-1:0] index_of(input logic [AW-1:0] a);
    return (a - BASE) >> STRIDE_LG;
  endfunction

  logic [AW-1:0] idx;
  logic          below;

  assign idx     = index_of(addr);
  assign below   = addr < BASE;
  assign size_ok = size == SZW'(FULL_BYTES);

  always_comb begin
    kind    = KIND_NONE;
    cpu_sel = '0;
    if (!below) begin
      if (idx == AW'(2 * NCPU)) kind = KIND_RAW;
      for (int i = 0; i < NCPU; i++) begin
        if (idx == AW'(i)) begin
          kind    = KIND_MASK;
          cpu_sel = CW'(i);
        end
        if (idx == AW'(NCPU + i)) begin
          kind    = KIND_PEND;
          cpu_sel = CW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/imr_raw_req.sv
module imr_raw_req #(
  parameter int NLINE = 64,
  localparam int LW = $clog2(NLINE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_valid,
  input  logic [LW-1:0]    set_line,
  input  logic             clr_valid,
  input  logic [LW-1:0]    clr_line,
  output logic [NLINE-1:0] raw_q,
  output logic [NLINE-1:0] raw_next,
  output logic             spurious_clr
);
  function automatic logic [NLINE-1:0] line_vec(input logic en, input logic [LW-1:0] n);
    logic [NLINE-1:0] v;
    v = '0;
    if (en) v[n] = 1'b1;
    return v;
  endfunction

  logic [NLINE-1:0] set_vec, clr_vec;

  assign set_vec      = line_vec(set_valid, set_line);
  assign clr_vec      = line_vec(clr_valid, clr_line);
  // set is applied after clear, so it wins on a shared line
  assign raw_next     = (raw_q & ~clr_vec) | set_vec;
  assign spurious_clr = clr_valid && !raw_q[clr_line];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_next;
  end
endmodule

// File: rtl/imr_cpu_lane.sv
module imr_cpu_lane #(
  parameter int NLINE = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic [NLINE-1:0] wdata,
  input  logic [NLINE-1:0] raw_next,
  output logic [NLINE-1:0] mask_q,
  output logic [NLINE-1:0] pend_q,
  output logic             irq
);
  function automatic logic [NLINE-1:0] gate(input logic [NLINE-1:0] m, input logic [NLINE-1:0] r);
    return m & r;
  endfunction

  logic [NLINE-1:0] mask_next;

  assign mask_next = mask_we ? wdata : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
      irq    <= 1'b0;
    end else begin
      mask_q <= mask_next;
      pend_q <= gate(mask_next, raw_next);
      irq    <= |pend_q;
    end
  end
endmodule

// File: rtl/imr_router.sv
module imr_router
  import imr_pkg::*;
#(
  parameter int NCPU       = 4,
  parameter int NLINE      = 64,
  parameter int AW         = 16,
  parameter int SZW        = 4,
  parameter int FULL_BYTES = 8,
  parameter logic [AW-1:0] BASE = 16'h4000,
  localparam int LW = $clog2(NLINE),
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_set_valid,
  input  logic [LW-1:0]    dev_set_line,
  input  logic             dev_clr_valid,
  input  logic [LW-1:0]    dev_clr_line,
  input  logic             csr_valid,
  input  logic             csr_write,
  input  logic [AW-1:0]    csr_addr,
  input  logic [SZW-1:0]   csr_size,
  input  logic [NLINE-1:0] csr_wdata,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [NLINE-1:0] rsp_rdata,
  output logic [NCPU-1:0]  irq_out
);
  reg_kind_e        kind;
  logic [CW-1:0]    cpu_sel;
  logic             size_ok;
  logic             acc_err;
  logic             mask_wr;
  logic [NLINE-1:0] raw_q, raw_next;
  logic             spurious_clr;
  logic [NLINE-1:0] mask_q [NCPU];
  logic [NLINE-1:0] pend_q [NCPU];
  logic [NLINE-1:0] rd_mux;

  imr_csr_decode #(
    .AW(AW), .SZW(SZW), .NCPU(NCPU), .STRIDE_LG(6),
    .FULL_BYTES(FULL_BYTES), .BASE(BASE)
  ) u_dec (
    .addr(csr_addr), .size(csr_size),
    .kind(kind), .cpu_sel(cpu_sel), .size_ok(size_ok)
  );

  assign acc_err = !size_ok || (kind == KIND_NONE) ||
                   (csr_write && (kind != KIND_MASK));
  assign mask_wr = csr_valid && csr_write && !acc_err;

  imr_raw_req #(.NLINE(NLINE)) u_raw (
    .clk(clk), .rst_n(rst_n),
    .set_valid(dev_set_valid), .set_line(dev_set_line),
    .clr_valid(dev_clr_valid), .clr_line(dev_clr_line),
    .raw_q(raw_q), .raw_next(raw_next), .spurious_clr(spurious_clr)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_lane
    imr_cpu_lane #(.NLINE(NLINE)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .mask_we(mask_wr && (cpu_sel == CW'(c))),
      .wdata(csr_wdata), .raw_next(raw_next),
      .mask_q(mask_q[c]), .pend_q(pend_q[c]), .irq(irq_out[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (kind)
      KIND_MASK: rd_mux = mask_q[cpu_sel];
      KIND_PEND: rd_mux = pend_q[cpu_sel];
      KIND_RAW:  rd_mux = raw_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= csr_valid;
      rsp_err   <= csr_valid && acc_err;
      rsp_rdata <= (csr_valid && !csr_write && !acc_err) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/imr_router_chk.sv
module imr_router_chk
  import imr_pkg::*;
#(
  parameter int NCPU       = 4,
  parameter int NLINE      = 64,
  parameter int SZW        = 4,
  parameter int FULL_BYTES = 8,
  localparam int LW = $clog2(NLINE)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dev_set_valid,
  input logic [LW-1:0]    dev_set_line,
  input logic             csr_valid,
  input logic             csr_write,
  input logic [SZW-1:0]   csr_size,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [NLINE-1:0] rsp_rdata,
  input logic [NCPU-1:0]  irq_out,
  input logic [NLINE-1:0] raw_q,
  input logic             spurious_clr,
  input reg_kind_e        kind
);
  // R1
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_set_valid |=> raw_q[$past(dev_set_line)]);

  // R3
  irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_out) |-> $past(|raw_q));

  // R5
  spurious_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spurious_clr && !dev_set_valid) |=> $stable(raw_q));

  // R7
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

  // R8
  narrow_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && csr_size != SZW'(FULL_BYTES)) |=> (rsp_valid && rsp_err));

  // R9
  ro_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && csr_write && (kind == KIND_PEND || kind == KIND_RAW)) |=> rsp_err);

  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(csr_valid));

  // R10
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (irq_out == '0 && !rsp_valid);
    end
  end
endmodule

bind imr_router imr_router_chk #(
  .NCPU(NCPU), .NLINE(NLINE), .SZW(SZW), .FULL_BYTES(FULL_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .dev_set_valid(dev_set_valid), .dev_set_line(dev_set_line),
  .csr_valid(csr_valid), .csr_write(csr_write), .csr_size(csr_size),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .irq_out(irq_out), .raw_q(raw_q), .spurious_clr(spurious_clr), .kind(kind)
);

// File: tb/tb_imr_router.sv
`timescale 1ns/1ps
module tb_imr_router;
  localparam logic [15:0] BASE = 16'h4000;
  localparam logic [1:0] OP_SET = 2'd0, OP_CLR = 2'd1, OP_WR = 2'd2, OP_RD = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [5:0]  arg;      // line for events, register index for CSR ops
    logic [3:0]  size;
    logic [63:0] data;
    logic [63:0] exp_data;
    logic        exp_err;
    logic [3:0]  exp_irq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam logic [63:0] TOP = 64'h8000_0000_0000_0000;
  localparam vec_t TBL [NV] = '{
    '{OP_SET, 6'd5,  4'd8, 64'h0,   64'h0,          1'b0, 4'b0000, 8'd1},  // R1
    '{OP_WR,  6'd0,  4'd8, 64'h20,  64'h0,          1'b0, 4'b0001, 8'd4},  // R4 enable waiting bit
    '{OP_RD,  6'd4,  4'd8, 64'h0,   64'h20,         1'b0, 4'b0001, 8'd2},  // R2
    '{OP_WR,  6'd1,  4'd8, 64'hFFFF_0000_0000_0000, 64'h0, 1'b0, 4'b0001, 8'd4},
    '{OP_SET, 6'd63, 4'd8, 64'h0,   64'h0,          1'b0, 4'b0011, 8'd3},  // R3
    '{OP_RD,  6'd8,  4'd8, 64'h0,   TOP | 64'h20,   1'b0, 4'b0011, 8'd1},
    '{OP_RD,  6'd5,  4'd8, 64'h0,   TOP,            1'b0, 4'b0011, 8'd2},
    '{OP_CLR, 6'd5,  4'd8, 64'h0,   64'h0,          1'b0, 4'b0010, 8'd5},  // R5
    '{OP_CLR, 6'd5,  4'd8, 64'h0,   64'h0,          1'b0, 4'b0010, 8'd5},  // spurious
    '{OP_RD,  6'd8,  4'd8, 64'h0,   TOP,            1'b0, 4'b0010, 8'd5},
    '{OP_WR,  6'd0,  4'd4, '1,      64'h0,          1'b1, 4'b0010, 8'd8},  // R8
    '{OP_RD,  6'd0,  4'd8, 64'h0,   64'h20,         1'b0, 4'b0010, 8'd8},
    '{OP_WR,  6'd6,  4'd8, '1,      64'h0,          1'b1, 4'b0010, 8'd9},  // R9
    '{OP_RD,  6'd6,  4'd8, 64'h0,   64'h0,          1'b0, 4'b0010, 8'd9},
    '{OP_WR,  6'd8,  4'd8, 64'h0,   64'h0,          1'b1, 4'b0010, 8'd9},
    '{OP_RD,  6'd8,  4'd8, 64'h0,   TOP,            1'b0, 4'b0010, 8'd9},
    '{OP_RD,  6'd12, 4'd8, 64'h0,   64'h0,          1'b1, 4'b0010, 8'd7},  // R7
    '{OP_RD,  6'd1,  4'd2, 64'h0,   64'h0,          1'b1, 4'b0010, 8'd8},
    '{OP_WR,  6'd1,  4'd8, 64'h0,   64'h0,          1'b0, 4'b0000, 8'd4},  // disable
    '{OP_WR,  6'd3,  4'd8, TOP,     64'h0,          1'b0, 4'b1000, 8'd4},
    '{OP_CLR, 6'd63, 4'd8, 64'h0,   64'h0,          1'b0, 4'b0000, 8'd3},
    '{OP_RD,  6'd7,  4'd8, 64'h0,   64'h0,          1'b0, 4'b0000, 8'd2},
    '{OP_RD,  6'd3,  4'd8, 64'h0,   TOP,            1'b0, 4'b0000, 8'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dev_set_valid = 1'b0, dev_clr_valid = 1'b0;
  logic [5:0]  dev_set_line = '0, dev_clr_line = '0;
  logic        csr_valid = 1'b0, csr_write = 1'b0;
  logic [15:0] csr_addr = '0;
  logic [3:0]  csr_size = '0;
  logic [63:0] csr_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [3:0]  irq_out;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  imr_router #(.BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n),
    .dev_set_valid(dev_set_valid), .dev_set_line(dev_set_line),
    .dev_clr_valid(dev_clr_valid), .dev_clr_line(dev_clr_line),
    .csr_valid(csr_valid), .csr_write(csr_write), .csr_addr(csr_addr),
    .csr_size(csr_size), .csr_wdata(csr_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr(input logic wr, input logic [15:0] a, input logic [3:0] sz,
                     input logic [63:0] d, output logic v, output logic e,
                     output logic [63:0] rd);
    @(negedge clk);
    csr_valid = 1'b1; csr_write = wr; csr_addr = a; csr_size = sz; csr_wdata = d;
    @(negedge clk);
    csr_valid = 1'b0; csr_write = 1'b0;
    v = rsp_valid; e = rsp_err; rd = rsp_rdata;
  endtask

  task automatic dev(input logic is_set, input logic [5:0] n);
    @(negedge clk);
    if (is_set) begin dev_set_valid = 1'b1; dev_set_line = n; end
    else        begin dev_clr_valid = 1'b1; dev_clr_line = n; end
    @(negedge clk);
    dev_set_valid = 1'b0; dev_clr_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    total++; fails++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic v, e;
    logic [63:0] rd;
    string tag;

    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 irq during reset", 64'(irq_out), 64'h0);
    chk("R10 no response during reset", 64'(rsp_valid), 64'h0);
    rst_n = 1'b1;
    csr(1'b0, BASE, 4'd8, 64'h0, v, e, rd);
    chk("R10 mask0 after reset", rd, 64'h0);
    csr(1'b0, BASE + 16'd512, 4'd8, 64'h0, v, e, rd);
    chk("R10 raw after reset", rd, 64'h0);
    chk("R11 response strobe", 64'(v), 64'h1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t t;
      t = TBL[i];
      tag = $sformatf("R%0d row%0d", t.req, i);
      case (t.op)
        OP_SET: dev(1'b1, t.arg);
        OP_CLR: dev(1'b0, t.arg);
        default: begin
          csr(t.op == OP_WR, BASE + 16'(t.arg) * 16'd64, t.size, t.data, v, e, rd);
          chk({tag, " rsp_valid"}, 64'(v), 64'h1);
          chk({tag, " rsp_err"}, 64'(e), 64'(t.exp_err));
          chk({tag, " rdata"}, rd, t.exp_data);
        end
      endcase
      repeat (2) @(negedge clk);
      chk({tag, " irq"}, 64'(irq_out), 64'(t.exp_irq));
    end

    // R7: low 6 address bits ignored, below base rejected
    csr(1'b0, BASE + 16'h0008, 4'd8, 64'h0, v, e, rd);
    chk("R7 offset inside stride", rd, 64'h20);
    csr(1'b0, BASE - 16'd64, 4'd8, 64'h0, v, e, rd);
    chk("R7 below base err", 64'(e), 64'h1);
    chk("R7 below base data", rd, 64'h0);

    // R3: irq lags pending by one clock (mask0 holds bit 5)
    @(negedge clk);
    dev_set_valid = 1'b1; dev_set_line = 6'd5;
    @(negedge clk);
    dev_set_valid = 1'b0;
    chk("R3 irq not yet", 64'(irq_out), 64'h0);
    @(negedge clk);
    chk("R3 irq after one clock", 64'(irq_out), 64'h1);

    // R11: read in same cycle as an event shows the old value
    @(negedge clk);
    csr_valid = 1'b1; csr_write = 1'b0; csr_addr = BASE + 16'd512; csr_size = 4'd8;
    dev_set_valid = 1'b1; dev_set_line = 6'd20;
    @(negedge clk);
    csr_valid = 1'b0; dev_set_valid = 1'b0;
    chk("R11 read before event", rsp_rdata, 64'h20);
    csr(1'b0, BASE + 16'd512, 4'd8, 64'h0, v, e, rd);
    chk("R11 read after event", rd, 64'h0010_0020);

    // R6: simultaneous set and clear on line 10, set wins
    csr(1'b1, BASE + 16'd128, 4'd8, 64'h400, v, e, rd);
    @(negedge clk);
    dev_set_valid = 1'b1; dev_set_line = 6'd10;
    dev_clr_valid = 1'b1; dev_clr_line = 6'd10;
    @(negedge clk);
    dev_set_valid = 1'b0; dev_clr_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 irq2 raised", 64'(irq_out), 64'b0101);
    csr(1'b0, BASE + 16'd384, 4'd8, 64'h0, v, e, rd);
    chk("R6 pend2", rd, 64'h400);

    // R10: reset in the middle of activity
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 irq cleared", 64'(irq_out), 64'h0);
    rst_n = 1'b1;
    csr(1'b0, BASE + 16'd128, 4'd8, 64'h0, v, e, rd);
    chk("R10 mask2 cleared", rd, 64'h0);
    csr(1'b0, BASE + 16'd512, 4'd8, 64'h0, v, e, rd);
    chk("R10 raw cleared", rd, 64'h0);
    csr(1'b0, BASE + 16'd256, 4'd8, 64'h0, v, e, rd);
    chk("R10 pend0 cleared", rd, 64'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule